// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block is a clocked front end for an external asynchronous static RAM of 64K words by 16 bits. A requester hands it one word operation at a time: an address, write data, a two-bit lane enable and a read/write flag. The block then sequences the memory's active-low chip enable, write enable, output enable and per-byte selects so that the memory's timing rules are met. The length of every phase is a parameter counted in system clocks, so the same RTL serves any speed grade once the nanosecond figures are divided by the clock period.

Writes are strobed by write enable. Address, byte selects and data are set up before the strobe falls and held past the rising edge, which is where the memory latches the data. Reads hold output enable low for an access window. The word is registered at the end of that window and returned with a one-cycle valid pulse. After each read, a gap passes before the block may drive the shared data bus again. This lets the memory's drivers turn off first.

The request side is a valid/ready pair. A request is taken on a clock edge where both are high. Ready is high only while the block is idle, so a requester may hold valid and its fields steady through a busy period and the block accepts them once ready returns. The response side has no back-pressure: the read-valid pulse lasts one cycle and the requester must take it then.

Top module: `sram_lane_ctrl`

## Requirements
- R1: Throughout reset and in the first cycle after it, chip enable, write enable and output enable are high, both byte selects are high, the bus drive enable is low, ready is high and the read-valid output is low.
- R2: Ready is high only while idle; a request is taken on an edge with valid and ready both high. A write with lanes enabled keeps ready low for T_SETUP+T_STROBE+T_HOLD cycles, and a read with lanes enabled keeps it low for T_ACCESS+1+T_TURN cycles.
- R3: A write pulls chip enable low with output enable high, waits T_SETUP cycles, then holds write enable low for exactly T_STROBE cycles. Chip enable stays low and data stays driven for T_HOLD cycles after write enable rises, and the memory stores the data on that rising edge.
- R4: While chip enable is low, the address and byte selects do not change. While the bus is driven, the outgoing data does not change.
- R5: A read keeps chip enable and output enable low with write enable high and the bus undriven for T_ACCESS cycles. The input word is registered on the edge that ends that window, and the read-valid output is high for exactly one cycle, in the cycle after the T_ACCESS-th edge after acceptance.
- R6: Lane enable bit 0 drives byte select bit 0, which governs data bits 7:0. Lane enable bit 1 drives byte select bit 1, which governs bits 15:8. A lane enable of 1 means the lane is used, and a byte select of 0 means the lane is selected. A partial write changes only the selected byte in memory.
- R7: For a read, returned bytes whose lane enable is 0 are zero, whatever the memory presents on them.
- R8: A request with lane enable 00 never pulls chip enable low. As a write it leaves memory unchanged and ready stays high. As a read it yields a read-valid pulse with zero data in the cycle after acceptance, and ready is low for that one cycle.
- R9: The bus drive enable is never high while output enable is low. After output enable rises, at least T_TURN+1 full cycles pass before the drive enable can rise.
- R10: Write enable and output enable are never low together, and write enable is low only while chip enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane enables, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_valid | output | 1 | One-cycle pulse marking read data |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_bs_n | output | 2 | Memory byte selects, active low, bit 0 = lower byte |
| mem_addr | output | 16 | Memory address |
| mem_dq_out | output | 16 | Data toward the memory |
| mem_dq_in | input | 16 | Data from the memory |
| mem_dq_oe | output | 1 | High when the block drives the data bus |

## Verification
The hardest situation to reach is a write that follows a read as closely as the port allows, because this is the one place where the bus turnaround gap can fail. The stimulus gets there by holding valid high with the next request's fields while the previous operation is still busy, so the block takes the request on the first idle edge. A memory model in the bench drives filler bytes on unselected lanes and flags any cycle where both sides drive the bus. This exposes wrong lane masking and missing turnaround in the same runs.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSETUP,
    ST_WSTROBE,
    ST_WHOLD,
    ST_RACCESS,
    ST_RCAPTURE,
    ST_RTURN
  } seq_state_t;

  function automatic int max_of5(input int a, input int b, input int c,
                                 input int d, input int e);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    if (e > m) m = e;
    return m;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] init,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= init;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_rd_capture.sv
`timescale 1ns/1ps
module sram_rd_capture #(
  parameter int DATA_W = 16,
  parameter int LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic              zero_rsp,
  input  logic [LANES-1:0]  lane_en,
  input  logic [DATA_W-1:0] dq_in,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  logic [DATA_W-1:0] lane_mask;

  for (genvar g = 0; g < LANES; g++) begin : g_mask
    assign lane_mask[g*8 +: 8] = {8{lane_en[g]}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= cap_en || zero_rsp;
      if (cap_en) begin
        rsp_rdata <= dq_in & lane_mask;
      end else if (zero_rsp) begin
        rsp_rdata <= '0;
      end
    end
  end

  // R5: the read-valid output never lasts two cycles
  assert_rsp_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

// File: rtl/sram_seq.sv
`timescale 1ns/1ps
module sram_seq
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int LANES    = DATA_W / 8,
  parameter int T_SETUP  = 1,
  parameter int T_STROBE = 2,
  parameter int T_HOLD   = 1,
  parameter int T_ACCESS = 2,
  parameter int T_TURN   = 1,
  parameter int CNT_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_be,
  output logic              req_ready,
  output logic              tmr_load,
  output logic [CNT_W-1:0]  tmr_init,
  input  logic              tmr_expired,
  output logic              cap_en,
  output logic              zero_rsp,
  output logic [LANES-1:0]  lane_en,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [LANES-1:0]  mem_bs_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe
);
  seq_state_t state_q, nxt;
  logic [LANES-1:0] be_q, be_nxt;
  logic accept, nxt_sel;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign be_nxt    = accept ? req_be : be_q;
  assign lane_en   = be_q;

  always_comb begin
    nxt      = state_q;
    tmr_load = 1'b0;
    tmr_init = '0;
    cap_en   = 1'b0;
    zero_rsp = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (req_be == '0) begin
            if (!req_write) begin
              nxt      = ST_RCAPTURE;
              zero_rsp = 1'b1;
            end
          end else if (req_write) begin
            nxt      = ST_WSETUP;
            tmr_load = 1'b1;
            tmr_init = CNT_W'(T_SETUP - 1);
          end else begin
            nxt      = ST_RACCESS;
            tmr_load = 1'b1;
            tmr_init = CNT_W'(T_ACCESS - 1);
          end
        end
      end
      ST_WSETUP: begin
        if (tmr_expired) begin
          nxt      = ST_WSTROBE;
          tmr_load = 1'b1;
          tmr_init = CNT_W'(T_STROBE - 1);
        end
      end
      ST_WSTROBE: begin
        if (tmr_expired) begin
          nxt      = ST_WHOLD;
          tmr_load = 1'b1;
          tmr_init = CNT_W'(T_HOLD - 1);
        end
      end
      ST_WHOLD: begin
        if (tmr_expired) nxt = ST_IDLE;
      end
      ST_RACCESS: begin
        if (tmr_expired) begin
          nxt    = ST_RCAPTURE;
          cap_en = 1'b1;
        end
      end
      ST_RCAPTURE: begin
        if (be_q == '0) begin
          nxt = ST_IDLE;
        end else begin
          nxt      = ST_RTURN;
          tmr_load = 1'b1;
          tmr_init = CNT_W'(T_TURN - 1);
        end
      end
      ST_RTURN: begin
        if (tmr_expired) nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  assign nxt_sel = (nxt == ST_WSETUP) || (nxt == ST_WSTROBE) ||
                   (nxt == ST_WHOLD)  || (nxt == ST_RACCESS);

  // every memory pin is a register loaded from the next state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      be_q       <= '0;
      mem_ce_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_bs_n   <= '1;
      mem_addr   <= '0;
      mem_dq_out <= '0;
      mem_dq_oe  <= 1'b0;
    end else begin
      state_q   <= nxt;
      be_q      <= be_nxt;
      mem_ce_n  <= !nxt_sel;
      mem_we_n  <= (nxt != ST_WSTROBE);
      mem_oe_n  <= (nxt != ST_RACCESS);
      mem_bs_n  <= nxt_sel ? ~be_nxt : '1;
      mem_dq_oe <= (nxt == ST_WSETUP) || (nxt == ST_WSTROBE) || (nxt == ST_WHOLD);
      if (accept && req_be != '0) begin
        mem_addr <= req_addr;
        if (req_write) mem_dq_out <= req_wdata;
      end
    end
  end

  // checker state: write-strobe length and cycles since output enable rose
  logic [CNT_W:0] we_low_cnt, oe_gap_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_low_cnt <= '0;
      oe_gap_cnt <= (CNT_W+1)'(T_TURN + 1);
    end else begin
      we_low_cnt <= mem_we_n ? '0 : we_low_cnt + 1'b1;
      if (!mem_oe_n) oe_gap_cnt <= '0;
      else if (oe_gap_cnt <= (CNT_W+1)'(T_TURN)) oe_gap_cnt <= oe_gap_cnt + 1'b1;
    end
  end

  assert_ready_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n));
  assert_strobe_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_low_cnt == (CNT_W+1)'(T_STROBE)));
  assert_addr_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> ($stable(mem_addr) && $stable(mem_bs_n)));
  assert_data_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));
  assert_no_drive_while_oe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);
  assert_turn_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (oe_gap_cnt > (CNT_W+1)'(T_TURN)));
  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && !mem_ce_n));
endmodule

// File: rtl/sram_lane_ctrl.sv
`timescale 1ns/1ps
module sram_lane_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int T_SETUP  = 1,
  parameter int T_STROBE = 2,
  parameter int T_HOLD   = 1,
  parameter int T_ACCESS = 2,
  parameter int T_TURN   = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [DATA_W/8-1:0] req_be,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic                mem_ce_n,
  output logic                mem_we_n,
  output logic                mem_oe_n,
  output logic [DATA_W/8-1:0] mem_bs_n,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_dq_out,
  input  logic [DATA_W-1:0]   mem_dq_in,
  output logic                mem_dq_oe
);
  localparam int LANES = DATA_W / 8;
  localparam int T_MAX = max_of5(T_SETUP, T_STROBE, T_HOLD, T_ACCESS, T_TURN);
  localparam int CNT_W = $clog2(T_MAX + 2) + 1;

  logic             tmr_load, tmr_expired, cap_en, zero_rsp;
  logic [CNT_W-1:0] tmr_init;
  logic [LANES-1:0] lane_en;

  initial begin
    assert_params_R2: assert (T_SETUP >= 1 && T_STROBE >= 1 && T_HOLD >= 1 &&
                              T_ACCESS >= 1 && T_TURN >= 1 && DATA_W % 8 == 0);
  end

  sram_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES),
    .T_SETUP(T_SETUP), .T_STROBE(T_STROBE), .T_HOLD(T_HOLD),
    .T_ACCESS(T_ACCESS), .T_TURN(T_TURN), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .req_ready(req_ready),
    .tmr_load(tmr_load), .tmr_init(tmr_init), .tmr_expired(tmr_expired),
    .cap_en(cap_en), .zero_rsp(zero_rsp), .lane_en(lane_en),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_bs_n(mem_bs_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe)
  );

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .init(tmr_init),
    .expired(tmr_expired)
  );

  sram_rd_capture #(.DATA_W(DATA_W), .LANES(LANES)) u_cap (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .zero_rsp(zero_rsp),
    .lane_en(lane_en), .dq_in(mem_dq_in), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata)
  );
endmodule

// File: tb/test_sram_lane_ctrl.sv
`timescale 1ns/1ps
module test_sram_lane_ctrl;
  localparam int TS = 2, TW = 3, TH = 1, TA = 3, TT = 2;
  localparam int WR_LAT = TS + TW + TH + 1;
  localparam int RD_RSP = TA + 1;
  localparam int RD_END = TA + TT + 2;
  localparam int NV = 11;
  // {write, addr, data, be, expected read data}
  localparam logic [50:0] VEC [NV] = '{
    {1'b1, 16'h0010, 16'hA1B2, 2'b11, 16'h0000},
    {1'b0, 16'h0010, 16'h0000, 2'b11, 16'hA1B2},
    {1'b1, 16'h0010, 16'hFFCC, 2'b01, 16'h0000},
    {1'b0, 16'h0010, 16'h0000, 2'b11, 16'hA1CC},
    {1'b1, 16'h0010, 16'h5566, 2'b10, 16'h0000},
    {1'b0, 16'h0010, 16'h0000, 2'b10, 16'h5500},
    {1'b0, 16'h0010, 16'h0000, 2'b01, 16'h00CC},
    {1'b1, 16'hFFFF, 16'h1234, 2'b11, 16'h0000},
    {1'b0, 16'hFFFF, 16'h0000, 2'b11, 16'h1234},
    {1'b1, 16'h0010, 16'h0000, 2'b00, 16'h0000},
    {1'b0, 16'h0010, 16'h0000, 2'b11, 16'h55CC}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic [1:0] req_be = '0;
  logic req_ready, rsp_valid, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [15:0] rsp_rdata, mem_addr, mem_dq_out, mem_dq_in;
  logic [1:0] mem_bs_n;

  int checks = 0, errors = 0;
  int cont_err = 0, width_err = 0, addr_err = 0, excl_err = 0, access_cnt = 0;
  int low_cnt = 0;
  logic [15:0] strobe_addr;
  logic prev_ce = 1'b1;
  logic [15:0] model [256];

  always #5 clk = ~clk;

  sram_lane_ctrl #(.T_SETUP(TS), .T_STROBE(TW), .T_HOLD(TH),
                   .T_ACCESS(TA), .T_TURN(TT)) i_sram_lane_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_be(req_be), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_bs_n(mem_bs_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
    .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
  );

  // memory model: filler bytes on unselected lanes, fixed pattern when off
  assign mem_dq_in = (!mem_ce_n && !mem_oe_n && mem_we_n) ?
    {mem_bs_n[1] ? 8'hEE : model[mem_addr[7:0]][15:8],
     mem_bs_n[0] ? 8'hEE : model[mem_addr[7:0]][7:0]} : 16'hBAD0;

  always @(posedge mem_we_n) begin
    if (mem_ce_n === 1'b0) begin
      if (!mem_bs_n[0]) model[mem_addr[7:0]][7:0]  = mem_dq_out[7:0];
      if (!mem_bs_n[1]) model[mem_addr[7:0]][15:8] = mem_dq_out[15:8];
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_dq_oe && !mem_oe_n) cont_err++;
      if (!mem_we_n && !mem_oe_n) excl_err++;
      if (!mem_we_n) begin
        if (low_cnt == 0) strobe_addr = mem_addr;
        else if (mem_addr != strobe_addr) addr_err++;
        low_cnt++;
      end else if (low_cnt != 0) begin
        if (low_cnt != TW) width_err++;
        low_cnt = 0;
      end
      if (prev_ce && !mem_ce_n) access_cnt++;
      prev_ce = mem_ce_n;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // issue one request; returns negedge counts to response and to ready
  task automatic issue(input logic wr, input logic [15:0] a, input logic [15:0] d,
                       input logic [1:0] be, output int lat_rsp, output int lat_end,
                       output logic [15:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 1'b0;
    lat_rsp = 0; lat_end = 0; rd = '0;
    for (int n = 1; n < 100; n++) begin
      @(negedge clk);
      if (rsp_valid && lat_rsp == 0) begin
        lat_rsp = n; rd = rsp_rdata;
      end
      if (req_ready) begin
        lat_end = n;
        break;
      end
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "R2", "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    int lr, le, acc0;
    logic [15:0] rd;
    for (int i = 0; i < 256; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_we_n && mem_oe_n && mem_bs_n == 2'b11 && !mem_dq_oe,
        "R1", "pins in reset", {mem_ce_n, mem_we_n, mem_oe_n, mem_bs_n, mem_dq_oe}, 6'b111110);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_ce_n && mem_we_n && mem_oe_n && mem_bs_n == 2'b11 && !mem_dq_oe,
        "R1", "pins after reset", {mem_ce_n, mem_we_n, mem_oe_n, mem_bs_n, mem_dq_oe}, 6'b111110);
    chk(req_ready && !rsp_valid, "R1", "ready/valid after reset", {req_ready, rsp_valid}, 2'b10);

    for (int i = 0; i < NV; i++) begin
      logic wr; logic [15:0] a, d, ex; logic [1:0] be;
      {wr, a, d, be, ex} = VEC[i];
      acc0 = access_cnt;
      issue(wr, a, d, be, lr, le, rd);
      if (wr) begin
        chk(le == ((be == 2'b00) ? 1 : WR_LAT), "R2", $sformatf("write busy v%0d", i), le,
            (be == 2'b00) ? 1 : WR_LAT);
        chk(access_cnt - acc0 == ((be == 2'b00) ? 0 : 1), "R8", $sformatf("strobes v%0d", i),
            access_cnt - acc0, (be == 2'b00) ? 0 : 1);
      end else begin
        chk(lr == RD_RSP, "R5", $sformatf("read latency v%0d", i), lr, RD_RSP);
        chk(rd == ex, "R6", $sformatf("read data v%0d (R7 masking)", i), rd, ex);
        chk(le == RD_END, "R2", $sformatf("read busy v%0d", i), le, RD_END);
      end
    end

    // R8: zero-lane read
    acc0 = access_cnt;
    issue(1'b0, 16'h0010, 16'h0000, 2'b00, lr, le, rd);
    chk(lr == 1 && rd == 16'h0000, "R8", "zero-lane read rsp", {lr[15:0], rd}, {16'd1, 16'h0000});
    chk(le == 2, "R8", "zero-lane read busy", le, 2);
    chk(access_cnt == acc0, "R8", "zero-lane read no access", access_cnt - acc0, 0);

    // R2/R9: read held pending during a write, taken on first idle edge
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h0020; req_wdata = 16'h7788; req_be = 2'b11;
    @(posedge clk);
    #1 req_write = 1'b0; req_addr = 16'h0010; req_be = 2'b11;
    le = 0;
    for (int n = 1; n < 100; n++) begin
      @(negedge clk);
      if (n == 1) chk(!req_ready, "R2", "ready low while busy", req_ready, 0);
      if (req_ready) begin le = n; break; end
    end
    chk(le == WR_LAT, "R2", "pending request waits", le, WR_LAT);
    @(posedge clk);
    #1 req_valid = 1'b0;
    lr = 0;
    for (int n = 1; n < 100; n++) begin
      @(negedge clk);
      if (rsp_valid) begin lr = n; rd = rsp_rdata; break; end
    end
    chk(lr == RD_RSP && rd == 16'h55CC, "R5", "read after back-pressure", rd, 16'h55CC);
    // R9: write issued right after the read
    issue(1'b1, 16'h0030, 16'h9ABC, 2'b11, lr, le, rd);
    issue(1'b0, 16'h0030, 16'h0000, 2'b11, lr, le, rd);
    chk(rd == 16'h9ABC, "R3", "write after read", rd, 16'h9ABC);
    chk(model[8'h20] == 16'h7788, "R3", "model at 0x20", model[8'h20], 16'h7788);
    issue(1'b1, 16'h0040, 16'h1111, 2'b11, lr, le, rd);

    repeat (3) @(negedge clk);
    chk(cont_err == 0, "R9", "bus contention cycles", cont_err, 0);
    chk(width_err == 0, "R3", "strobe width mismatches", width_err, 0);
    chk(addr_err == 0, "R4", "address moved under strobe", addr_err, 0);
    chk(excl_err == 0, "R10", "write and output enable both low", excl_err, 0);
    summary();
  end
endmodule